// File: doc/BRIEF.md
# Transmit Line Silence and Ground-Fault Monitor

This block watches the transmit side of a bipolar line pair. Two comparators, one for each polarity, report pulses on the line. A third input reports a ground fault on either conductor. The block runs on a fast system clock. A one-cycle bit strobe marks the end of each transmit bit period. The block drives one alarm flag. The flag goes high when no mark has reached the line for a configurable number of bit periods, or while a ground fault is present.

Each of the three inputs first passes through a debounce stage. A comparator level counts only after it has held for a set number of system clock cycles, so short glitches are discarded. A rail counts as showing a mark in a bit period when its filtered level is high at any time in that period. At each strobe a bit with no mark adds one to a space counter. The counter stops at its limit and does not wrap. Reaching the limit latches a silence flag.

The silence flag clears in two ways: when a bit with a mark completes, or when a single-cycle clear command is given. The ground-fault part needs no clear. It follows the filtered fault input, so the alarm drops by itself once the fault has been gone for the filter length. All pins are plain level or strobe signals. No data stream passes through the block, so it has no handshake and no back-pressure.

Top module: `tx_line_monitor`

## Requirements
- R1: After reset, `alarm` goes high at the clock edge that samples the SPACE_LIMIT-th consecutive `bit_stb` pulse of a bit period containing no qualified mark, and not earlier.
- R2: A qualified mark on either rail (`mark_pos` or `mark_neg`, active high) within a bit period clears the silence part of the alarm and restarts the space count at 0 at that period's strobe. Before that strobe, the alarm is unchanged.
- R3: A high `clr_cmd` for one cycle clears the silence part of the alarm and the space count at the next edge. It takes priority over a `bit_stb` in the same cycle.
- R4: When `gnd_fault` is sampled high on GND_FILT_CYC consecutive clock edges, `alarm` is high after the last of them, whatever the silence state. `clr_cmd` does not clear this alarm.
- R5: The ground-fault alarm clears by itself after `gnd_fault` is sampled low on GND_FILT_CYC consecutive edges. A high run shorter than GND_FILT_CYC edges never raises it.
- R6: A rail pulse sampled high on fewer than RAIL_FILT_CYC consecutive edges is ignored. A pulse of RAIL_FILT_CYC or more edges counts as a mark.
- R7: The space count saturates at SPACE_LIMIT. The alarm stays high through any number of further mark-free bit periods until a mark or a clear.
- R8: While `rst_n` is low, `alarm` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One-cycle pulse closing each transmit bit period |
| mark_pos | input | 1 | Positive-rail comparator, high when a pulse is seen |
| mark_neg | input | 1 | Negative-rail comparator, high when a pulse is seen |
| gnd_fault | input | 1 | Ground-fault indication, high while a fault is present |
| clr_cmd | input | 1 | One-cycle command that clears the silence alarm |
| alarm | output | 1 | High on line silence or on a ground fault |

## Verification
The bench builds the block with SPACE_LIMIT=5, RAIL_FILT_CYC=3 and GND_FILT_CYC=4. With these values every space count, every pulse width on both sides of each filter threshold, and every rise and fall step of the ground filter can be covered in full. The bench sweeps the number of mark-free bits well past the limit to cover saturation. It sweeps rail pulse widths from one cycle up to one more than the filter length on each rail. It sweeps ground-fault hold times against every sampling point of both the rise and the fall. It also covers the case of a clear and a strobe arriving in the same cycle.

// File: rtl/tlm_pkg.sv
package tlm_pkg;
  // Sources watched by the monitor, in debounce-bank order.
  typedef enum int unsigned {
    SRC_POS = 0,
    SRC_NEG = 1,
    SRC_GND = 2
  } src_e;

  localparam int unsigned NUM_RAIL = 2;
  localparam int unsigned NUM_SRC  = 3;

  // Width of a counter that must hold values 0..max_val.
  function automatic int unsigned cnt_width(int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/tlm_debounce.sv
// Output follows the input only after LEN consecutive samples that differ
// from the current output.
module tlm_debounce #(
  parameter int unsigned LEN = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic q
);
  localparam int unsigned CW = tlm_pkg::cnt_width(LEN);

  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= '0;
      q   <= 1'b0;
    end else if (din == q) begin
      run <= '0;
    end else if (run == CW'(LEN - 1)) begin
      run <= '0;
      q   <= din;
    end else begin
      run <= run + 1'b1;
    end
  end
endmodule

// File: rtl/tlm_mark_window.sv
// Remembers whether any filtered rail was high within the current bit period.
module tlm_mark_window #(
  parameter int unsigned RAILS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             clr,
  input  logic [RAILS-1:0] rail_q,
  output logic             mark_in_bit
);
  logic seen;
  logic any_rail;

  assign any_rail    = |rail_q;
  assign mark_in_bit = seen | any_rail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               seen <= 1'b0;
    else if (clr || bit_stb)  seen <= 1'b0;
    else if (any_rail)        seen <= 1'b1;
  end
endmodule

// File: rtl/tlm_space_count.sv
// Saturating count of mark-free bit periods with a latched silence flag.
module tlm_space_count #(
  parameter int unsigned LIMIT = 63,
  localparam int unsigned CW   = tlm_pkg::cnt_width(LIMIT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_stb,
  input  logic          clr,
  input  logic          mark_in_bit,
  output logic          silent,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      silent <= 1'b0;
    end else if (clr) begin
      count  <= '0;
      silent <= 1'b0;
    end else if (bit_stb) begin
      if (mark_in_bit) begin
        count  <= '0;
        silent <= 1'b0;
      end else begin
        if (count < CW'(LIMIT)) count <= count + 1'b1;
        if (count >= CW'(LIMIT - 1)) silent <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tx_line_monitor.sv
module tx_line_monitor #(
  parameter int unsigned SPACE_LIMIT   = 63,
  parameter int unsigned RAIL_FILT_CYC = 15,
  parameter int unsigned GND_FILT_CYC  = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic mark_pos,
  input  logic mark_neg,
  input  logic gnd_fault,
  input  logic clr_cmd,
  output logic alarm
);
  import tlm_pkg::*;

  localparam int unsigned CNT_W = cnt_width(SPACE_LIMIT);

  logic [NUM_SRC-1:0] src_raw;
  logic [NUM_SRC-1:0] src_q;
  logic               mark_in_bit;
  logic               silent;
  logic               gnd_q;
  logic [CNT_W-1:0]   space_cnt;

  assign src_raw[SRC_POS] = mark_pos;
  assign src_raw[SRC_NEG] = mark_neg;
  assign src_raw[SRC_GND] = gnd_fault;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_filt
    localparam int unsigned LEN = (s == SRC_GND) ? GND_FILT_CYC : RAIL_FILT_CYC;
    tlm_debounce #(.LEN(LEN)) u_deb (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (src_raw[s]),
      .q    (src_q[s])
    );
  end

  assign gnd_q = src_q[SRC_GND];

  tlm_mark_window #(.RAILS(NUM_RAIL)) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_stb    (bit_stb),
    .clr        (clr_cmd),
    .rail_q     (src_q[NUM_RAIL-1:0]),
    .mark_in_bit(mark_in_bit)
  );

  tlm_space_count #(.LIMIT(SPACE_LIMIT)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_stb    (bit_stb),
    .clr        (clr_cmd),
    .mark_in_bit(mark_in_bit),
    .silent     (silent),
    .count      (space_cnt)
  );

  assign alarm = silent | gnd_q;
endmodule

// File: rtl/tlm_checker.sv
module tlm_checker #(
  parameter int unsigned LIMIT = 63,
  localparam int unsigned CW   = tlm_pkg::cnt_width(LIMIT)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_stb,
  input logic          clr_cmd,
  input logic          gnd_fault,
  input logic          mark_in_bit,
  input logic          silent,
  input logic          gnd_q,
  input logic [CW-1:0] count,
  input logic          alarm
);
  // R1: the silence flag only rises on a strobe that no clear overrode
  a_r1_rise_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(silent) |-> ($past(bit_stb) && !$past(clr_cmd)));

  // R2: a completed bit with a mark restarts the count
  a_r2_mark_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !clr_cmd && mark_in_bit) |=> (!silent && count == '0));

  // R3: clear wins and empties the count
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd |=> (!silent && count == '0));

  // R4: a filtered ground fault always shows on the alarm
  a_r4_gnd_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    gnd_q |-> alarm);

  // R4: the ground flag only rises after the fault input was high
  a_r4_gnd_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnd_q) |-> $past(gnd_fault));

  // R5: the ground flag only falls after the fault input was low
  a_r5_gnd_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gnd_q) |-> !$past(gnd_fault));

  // R7: count never passes its limit
  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(LIMIT));

  // R7: silence holds until a mark or a clear
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (silent && !clr_cmd && !(bit_stb && mark_in_bit)) |=> silent);
endmodule

bind tx_line_monitor tlm_checker #(.LIMIT(SPACE_LIMIT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_stb    (bit_stb),
  .clr_cmd    (clr_cmd),
  .gnd_fault  (gnd_fault),
  .mark_in_bit(mark_in_bit),
  .silent     (silent),
  .gnd_q      (gnd_q),
  .count      (space_cnt),
  .alarm      (alarm)
);

// File: tb/sim_tx_line_monitor.sv
module sim_tx_line_monitor;
  localparam int LIM  = 5;
  localparam int RF   = 3;
  localparam int GF   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_stb = 1'b0;
  logic mark_pos = 1'b0;
  logic mark_neg = 1'b0;
  logic gnd_fault = 1'b0;
  logic clr_cmd = 1'b0;
  logic alarm;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tx_line_monitor #(.SPACE_LIMIT(LIM), .RAIL_FILT_CYC(RF), .GND_FILT_CYC(GF)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .mark_pos(mark_pos),
    .mark_neg(mark_neg), .gnd_fault(gnd_fault), .clr_cmd(clr_cmd), .alarm(alarm)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s alarm=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One strobe plus a few quiet cycles: one bit period.
  task automatic strobe();
    @(negedge clk) bit_stb = 1'b1;
    @(negedge clk) bit_stb = 1'b0;
    idle(3);
  endtask

  task automatic spaces(input int n);
    for (int i = 0; i < n; i++) strobe();
  endtask

  task automatic clear();
    @(negedge clk) clr_cmd = 1'b1;
    @(negedge clk) clr_cmd = 1'b0;
  endtask

  task automatic pulse(input int rail, input int w);
    @(negedge clk);
    if (rail == 0) mark_pos = 1'b1; else mark_neg = 1'b1;
    repeat (w) @(negedge clk);
    mark_pos = 1'b0;
    mark_neg = 1'b0;
    idle(RF + 2);
  endtask

  initial begin
    // R8: reset state
    idle(3);
    check("R8", alarm, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    idle(2);
    check("R8", alarm, 1'b0);

    // R1 and R7: sweep mark-free bit count past the limit
    for (int k = 1; k <= LIM + 3; k++) begin
      strobe();
      check(k > LIM ? "R7" : "R1", alarm, (k >= LIM) ? 1'b1 : 1'b0);
    end
    spaces(20);
    check("R7", alarm, 1'b1);

    // R3: clear drops the alarm and restarts the count
    clear();
    check("R3", alarm, 1'b0);
    spaces(LIM - 1);
    check("R3", alarm, 1'b0);
    strobe();
    check("R3", alarm, 1'b1);

    // R6 and R2: pulse width sweep on each rail
    for (int r = 0; r < 2; r++) begin
      for (int w = 1; w <= RF + 1; w++) begin
        clear();
        spaces(LIM - 1);
        check("R6", alarm, 1'b0);
        pulse(r, w);
        strobe();
        check("R6", alarm, (w < RF) ? 1'b1 : 1'b0);
        if (w >= RF) begin
          spaces(LIM - 1);
          check("R2", alarm, 1'b0);
          strobe();
          check("R2", alarm, 1'b1);
        end
      end
    end

    // R2: mark clears an alarm that is already set, at the strobe
    clear();
    spaces(LIM + 2);
    check("R2", alarm, 1'b1);
    pulse(1, RF);
    check("R2", alarm, 1'b1);
    strobe();
    check("R2", alarm, 1'b0);

    // R3: clear and strobe together, clear wins
    clear();
    spaces(LIM - 1);
    @(negedge clk) begin bit_stb = 1'b1; clr_cmd = 1'b1; end
    @(negedge clk) begin bit_stb = 1'b0; clr_cmd = 1'b0; end
    check("R3", alarm, 1'b0);
    spaces(LIM - 1);
    check("R3", alarm, 1'b0);
    strobe();
    check("R3", alarm, 1'b1);

    // R4 and R5: ground-fault rise and fall sweep
    clear();
    for (int w = 1; w <= GF + 1; w++) begin
      @(negedge clk) gnd_fault = 1'b1;
      for (int j = 1; j <= w; j++) begin
        @(negedge clk);
        check("R4", alarm, (j >= GF) ? 1'b1 : 1'b0);
      end
      gnd_fault = 1'b0;
      for (int j = 1; j <= GF + 1; j++) begin
        @(negedge clk);
        check("R5", alarm, (w >= GF && j < GF) ? 1'b1 : 1'b0);
      end
      idle(2);
    end

    // R4: clear command does not remove a ground alarm
    @(negedge clk) gnd_fault = 1'b1;
    idle(GF + 1);
    check("R4", alarm, 1'b1);
    clear();
    check("R4", alarm, 1'b1);
    gnd_fault = 1'b0;
    idle(GF + 1);
    check("R5", alarm, 1'b0);

    // R5: ground fall leaves a latched silence alarm in place
    spaces(LIM);
    @(negedge clk) gnd_fault = 1'b1;
    idle(GF + 1);
    gnd_fault = 1'b0;
    idle(GF + 1);
    check("R5", alarm, 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog alarm=%b expected=finished", alarm);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule